// File: doc/BRIEF.md
# Iterative Fibonacci Sequencer

This unit computes the Fibonacci term fib(n) for an unsigned index n given when a request is accepted, with fib(0) = 0 and fib(1) = 1. A small controller with three states (waiting, iterating, finished) steers a datapath. The datapath has two term registers, one for the older term and one for the newer term, and a down-counter that holds the number of iterations still to run. Each cycle in the iterating state either produces the next term or ends the run.

A caller waits for `ready`, then raises `start` for one cycle with the index on `idx`. The unit then works on its own. It pulses `done` for one cycle, and in that cycle `result` carries the term. Sums wrap modulo 2^RES_W, and no overflow is flagged.

Top module: `fib_seq_unit`

## Requirements
- R1: A synchronous active-high reset puts the unit into the waiting state with every register at zero. After reset, `ready` = 1, `done` = 0 and `result` = 0. This holds even when reset arrives in the middle of a run.
- R2: `ready` is 1 exactly while the unit is waiting. It is 0 from the edge that accepts `start` up to and including the cycle in which `done` is high.
- R3: In the cycle where `done` is 1, `result` equals fib(n) for the index n that was accepted.
- R4: `done` stays high for exactly one cycle. In the following cycle the unit is waiting again (`ready` = 1, `done` = 0).
- R5: `done` goes high after the max(n,1)-th rising edge that follows the edge which sampled `start`. For n ≥ 2, one term is produced per cycle.
- R6: While the unit is not waiting, `start` and `idx` are ignored. A pulse in that time changes neither the result nor the latency, and the index is captured only when the request is accepted.
- R7: Index 0 yields 0 and index 1 yields 1. Each takes one iterating cycle.
- R8: Terms that exceed RES_W bits are reported modulo 2^RES_W. For the default 32-bit width, fib(47) = 2971215073 is exact and fib(48) wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, sampled only while waiting |
| idx | input | IDX_W | Index of the requested term |
| ready | output | 1 | High while waiting for a request |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | RES_W | Computed term, valid while done is high |

## Verification
The assertions assume that `start` may be driven in any cycle but is acted on only while the unit is waiting. They also assume that a run always advances to `done` and is never stalled by an input. The stimulus keeps within this. It pulses `start` only when `ready` is seen high, except for deliberate stray pulses and index changes in the middle of a run, which exercise the ignore rule. Every index of the default 6-bit space is swept, so the expected terms, including the wrapped ones, come from an independent sum in the bench.

// File: rtl/fib_pkg.sv
package fib_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_OP   = 2'd1,
        FS_DONE = 2'd2
    } fsm_state_e;

    typedef enum logic [1:0] {
        DP_HOLD = 2'd0,
        DP_LOAD = 2'd1,
        DP_STEP = 2'd2,
        DP_ZERO = 2'd3
    } dp_op_e;

    // Selects the datapath action for one cycle of the iterate state.
    function automatic dp_op_e op_for_count(input logic cnt_zero, input logic cnt_one);
        if (cnt_zero)
            return DP_ZERO;
        else if (cnt_one)
            return DP_HOLD;
        else
            return DP_STEP;
    endfunction

endpackage

// File: rtl/fib_ctrl.sv
module fib_ctrl
    import fib_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   cnt_zero,
    input  logic   cnt_one,
    output dp_op_e dp_op,
    output logic   ready,
    output logic   done
);

    fsm_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= FS_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        dp_op   = DP_HOLD;
        case (state_q)
            FS_IDLE: begin
                if (start) begin
                    dp_op   = DP_LOAD;
                    state_d = FS_OP;
                end
            end
            FS_OP: begin
                dp_op = op_for_count(cnt_zero, cnt_one);
                if (cnt_zero || cnt_one)
                    state_d = FS_DONE;
            end
            FS_DONE: begin
                state_d = FS_IDLE;
            end
            default: begin
                state_d = FS_IDLE;
            end
        endcase
    end

    assign ready = (state_q == FS_IDLE);
    assign done  = (state_q == FS_DONE);

endmodule

// File: rtl/fib_dpath.sv
module fib_dpath
    import fib_pkg::*;
#(
    parameter int RES_W = 32,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  dp_op_e           dp_op,
    input  logic [IDX_W-1:0] idx,
    output logic             cnt_zero,
    output logic             cnt_one,
    output logic [RES_W-1:0] result
);

    localparam logic [IDX_W-1:0] CNT_ONE = IDX_W'(1);

    typedef struct packed {
        logic [RES_W-1:0] older;
        logic [RES_W-1:0] newer;
        logic [IDX_W-1:0] left;
    } term_regs_t;

    term_regs_t regs_q, regs_d;

    always_comb begin
        regs_d = regs_q;
        case (dp_op)
            DP_LOAD: begin
                regs_d.older = '0;
                regs_d.newer = RES_W'(1);
                regs_d.left  = idx;
            end
            DP_STEP: begin
                regs_d.newer = regs_q.newer + regs_q.older;
                regs_d.older = regs_q.newer;
                regs_d.left  = regs_q.left - CNT_ONE;
            end
            DP_ZERO: begin
                regs_d.newer = '0;
            end
            default: begin
                regs_d = regs_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    assign cnt_zero = (regs_q.left == '0);
    assign cnt_one  = (regs_q.left == CNT_ONE);
    assign result   = regs_q.newer;

endmodule

// File: rtl/fib_seq_unit.sv
module fib_seq_unit
    import fib_pkg::*;
#(
    parameter int RES_W = 32,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] idx,
    output logic             ready,
    output logic             done,
    output logic [RES_W-1:0] result
);

    dp_op_e dp_op;
    logic   cnt_zero;
    logic   cnt_one;

    fib_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .dp_op    (dp_op),
        .ready    (ready),
        .done     (done)
    );

    fib_dpath #(
        .RES_W (RES_W),
        .IDX_W (IDX_W)
    ) u_dpath (
        .clk      (clk),
        .rst      (rst),
        .dp_op    (dp_op),
        .idx      (idx),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .result   (result)
    );

endmodule

// File: rtl/fib_seq_unit_chk.sv
module fib_seq_unit_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic ready,
    input logic done
);

    // R2
    ready_not_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !ready);

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> (!ready && !done));

    // R2
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> ready);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && ready));

    // R6
    busy_stays_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && !done) |=> !ready);

endmodule

bind fib_seq_unit fib_seq_unit_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ready (ready),
    .done  (done)
);

// File: tb/fib_seq_unit_bench.sv
module fib_seq_unit_bench;

    localparam int CLK_P = 10;
    localparam int RES_W = 32;
    localparam int IDX_W = 6;
    localparam int WATCHDOG = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [IDX_W-1:0] idx = '0;
    logic             ready;
    logic             done;
    logic [RES_W-1:0] result;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fib_seq_unit #(.RES_W(RES_W), .IDX_W(IDX_W)) u_fib_seq_unit (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .idx    (idx),
        .ready  (ready),
        .done   (done),
        .result (result)
    );

    function automatic logic [RES_W-1:0] fib_ref(input int n);
        logic [RES_W-1:0] a = '0;
        logic [RES_W-1:0] b = RES_W'(1);
        logic [RES_W-1:0] t;
        if (n == 0) return '0;
        for (int k = 1; k < n; k++) begin
            t = a + b;
            a = b;
            b = t;
        end
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_reset_state(input string tag);
        check(ready == 1'b1, {tag, " R1 ready"}, ready, 1);
        check(done == 1'b0, {tag, " R1 done"}, done, 0);
        check(result == '0, {tag, " R1 result"}, result, 0);
    endtask

    task automatic run_one(input int n, input bit noise);
        int edges;
        int exp_edges;
        bit busy_ok;
        logic [RES_W-1:0] exp_res;
        exp_res   = fib_ref(n);
        exp_edges = 1 + ((n < 1) ? 1 : n);
        busy_ok   = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R2 ready before request", ready, 1);
        start = 1'b1;
        idx   = IDX_W'(n);
        @(negedge clk);
        edges = 1;
        start = 1'b0;
        while (!done && edges < 200) begin
            if (ready) busy_ok = 1'b0;
            if (noise && edges == 1) begin
                start = 1'b1;
                idx   = ~IDX_W'(n);
            end else begin
                start = 1'b0;
                idx   = IDX_W'(edges * 7);
            end
            @(negedge clk);
            edges++;
        end
        start = 1'b0;
        check(busy_ok, "R2 ready low while busy", busy_ok, 1);
        check(done == 1'b1, "R5 done reached", done, 1);
        check(edges == exp_edges, "R5 latency", edges, exp_edges);
        check(ready == 1'b0, "R2 ready low in done cycle", ready, 0);
        if (n <= 1)
            check(result == exp_res, "R7 special index result", result, exp_res);
        else if (n >= 48)
            check(result == exp_res, "R8 wrapped result", result, exp_res);
        else if (noise)
            check(result == exp_res, "R6 result with stray request", result, exp_res);
        else
            check(result == exp_res, "R3 result", result, exp_res);
        @(negedge clk);
        check(done == 1'b0, "R4 done width", done, 0);
        check(ready == 1'b1, "R4 ready after done", ready, 1);
    endtask

    initial begin
        while (!finished && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state("initial");
        rst = 1'b0;

        for (int n = 0; n < (1 << IDX_W); n++)
            run_one(n, 1'b0);

        run_one(0, 1'b1);
        run_one(1, 1'b1);
        run_one(2, 1'b1);
        run_one(30, 1'b1);

        // R1: reset in the middle of a run
        @(negedge clk);
        start = 1'b1;
        idx   = IDX_W'(20);
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state("mid-run");
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b1 && done == 1'b0, "R1 idle after reset", ready, 1);

        run_one(47, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule